// File: doc/BRIEF.md
# Adaptive Recursive Temporal Noise Filter

This block reduces temporal noise in a stream of 8-bit video samples with a first-order recursive filter. For each pixel it receives the sample of the current field and the already filtered sample at the same position from the previous field. It returns a blend of the two, `prev + k*(cur - prev)`. A small k keeps most of the history and suppresses noise. A k of one passes the new sample straight through, which suits moving areas.

The coefficient k normally adapts to the local change. The absolute difference between the two samples is scaled by a programmable gain and then compared against a ladder of eight programmable thresholds. A fixed-k mode overrides the ladder for the whole picture. A split-screen mode forces fixed k to the left of a given column, so that filtered and adaptive results can be viewed side by side. One instance serves one colour component. A parameter chooses whether it takes its gain, fixed value and mode bit from the luma or the chroma mode register. The threshold registers are shared.

Top module: `tnr_blend`

## Requirements
- R1: After reset, `out_valid` and `out_pix` are 0. All configuration registers are 0, so every threshold is disabled, the gain is x1 and the mode is adaptive. In this state every sample passes through unchanged (k = 16/16).
- R2: A sample accepted with `in_valid` high appears on `out_pix` with `out_valid` high exactly two clock edges later.
- R3: The output is `(prev*(16-k) + cur*k + 8) >> 4`, with k in sixteenths, clipped to 255. It therefore always lies between `prev` and `cur` inclusive.
- R4: A write to address 0x10+i (i = 0..3) loads threshold register i. Its low nibble is the threshold for rung 2i and its high nibble the threshold for rung 2i+1. Rung j has threshold `code << (j/2)`, which gives steps of 1, 2, 4 and 8 for the four register pairs.
- R5: Rung 0 gives k = 1/16, and rung j ≥ 1 gives k = 2j/16. The rungs are tried from 0 upward, and the first one whose threshold is strictly above the scaled difference sets k. If no rung matches, k = 16/16.
- R6: Mode-register bits [6:4] select the gain applied to |cur - prev|: 0 = x1, 1 = x1/2, 2 = x1/4, 3 = x1/8, 4 = x2, 5 = x4, 6 and 7 = x1. Right shifts truncate, and the scaled value saturates at 255.
- R7: When mode-register bit 7 is set, k is fixed. It is taken from bits [3:0] as code/16 for codes 0 to 14, and code 15 gives 16/16.
- R8: While `split_en` is high, pixels with `in_col < split_col` use the fixed k whatever bit 7 holds. Pixels at or right of `split_col` follow bit 7.
- R9: With `COMP` = 0 the mode register is at 0x14, and with `COMP` = 1 it is at 0x15. Writes to the other component's mode address, or to any address outside the threshold and mode set, change nothing.
- R10: A cycle with `in_valid` low produces no output two edges later: `out_valid` is low and `out_pix` holds its value.
- R11: When `cur` equals `prev`, the output equals that value for every k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| split_en | input | 1 | Split-screen mode enable |
| split_col | input | COLW | First column that uses the mode-selected k in split mode |
| in_valid | input | 1 | Input sample valid |
| in_col | input | COLW | Column of the input sample |
| in_cur | input | DW | Current-field sample |
| in_prev | input | DW | Filtered previous-field sample |
| out_valid | output | 1 | Output sample valid |
| out_pix | output | DW | Filtered sample |

## Verification
The assertions take for granted that `in_valid`, `in_cur` and `in_prev` hold known values on every clock edge after reset, including edges where no sample is offered. The range and equal-input properties look two edges back at the data inputs regardless of configuration, so they hold under any change to the thresholds or mode. The bench drives every input to a defined value from time zero. It changes inputs only on falling edges and keeps the data buses at their last values while `in_valid` is low.

// File: rtl/tnr_blend.sv
module tnr_blend #(
  parameter int DW = 8,
  parameter int COLW = 11,
  parameter bit COMP = 1'b0,
  parameter logic [7:0] THR_BASE = 8'h10,
  parameter logic [7:0] LUMA_ADDR = 8'h14,
  parameter logic [7:0] CHROMA_ADDR = 8'h15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            split_en,
  input  logic [COLW-1:0] split_col,
  input  logic            in_valid,
  input  logic [COLW-1:0] in_col,
  input  logic [DW-1:0]   in_cur,
  input  logic [DW-1:0]   in_prev,
  output logic            out_valid,
  output logic [DW-1:0]   out_pix
);

  localparam int NRUNG = 8;
  localparam int NTREG = NRUNG / 2;
  localparam int KW = 5;
  localparam int SW = DW + 3;
  localparam int BW = DW + KW + 2;
  localparam logic [7:0] MODE_ADDR = COMP ? CHROMA_ADDR : LUMA_ADDR;
  localparam logic [SW-1:0] SMAX = SW'((1 << DW) - 1);
  localparam logic [BW-1:0] BMAX = BW'((1 << DW) - 1);

  logic [7:0] thr_reg [NTREG];
  logic [7:0] mode_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTREG; i++) thr_reg[i] <= '0;
      mode_reg <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NTREG; i++)
        if (cfg_addr == THR_BASE + 8'(i)) thr_reg[i] <= cfg_wdata;
      if (cfg_addr == MODE_ADDR) mode_reg <= cfg_wdata;
    end
  end

  wire [2:0] gain_sel = mode_reg[6:4];
  wire       fix_sel  = mode_reg[7];
  wire [3:0] fix_code = mode_reg[3:0];

  wire [DW-1:0] diff = (in_cur >= in_prev) ? in_cur - in_prev : in_prev - in_cur;

  logic [SW-1:0] gained;
  always_comb begin
    case (gain_sel)
      3'd1:    gained = SW'(diff) >> 1;
      3'd2:    gained = SW'(diff) >> 2;
      3'd3:    gained = SW'(diff) >> 3;
      3'd4:    gained = SW'(diff) << 1;
      3'd5:    gained = SW'(diff) << 2;
      default: gained = SW'(diff);
    endcase
  end

  wire [SW-1:0] sdiff = (gained > SMAX) ? SMAX : gained;

  logic [NRUNG-1:0] hit;
  for (genvar j = 0; j < NRUNG; j++) begin : g_rung
    wire [3:0]    code = thr_reg[j/2][(j%2)*4 +: 4];
    wire [SW-1:0] thr  = SW'(code) << (j/2);
    assign hit[j] = sdiff < thr;
  end

  logic [KW-1:0] k_adapt;
  always_comb begin
    k_adapt = KW'(16);
    for (int j = NRUNG - 1; j >= 0; j--)
      if (hit[j]) k_adapt = (j == 0) ? KW'(1) : KW'(2 * j);
  end

  wire [KW-1:0] k_fixed   = (fix_code == 4'hF) ? KW'(16) : KW'(fix_code);
  wire          use_fixed = (split_en && (in_col < split_col)) || fix_sel;
  wire [KW-1:0] k_sel     = use_fixed ? k_fixed : k_adapt;

  logic          s1_valid;
  logic [DW-1:0] s1_cur, s1_prev;
  logic [KW-1:0] s1_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_cur   <= '0;
      s1_prev  <= '0;
      s1_k     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_cur  <= in_cur;
        s1_prev <= in_prev;
        s1_k    <= k_sel;
      end
    end
  end

  wire [BW-1:0] acc   = BW'(s1_prev) * BW'(KW'(16) - s1_k) + BW'(s1_cur) * BW'(s1_k) + BW'(8);
  wire [BW-1:0] shr   = acc >> 4;
  wire [DW-1:0] blend = (shr > BMAX) ? DW'(BMAX) : shr[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= blend;
    end
  end

endmodule

// File: rtl/tnr_blend_chk.sv
module tnr_blend_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_cur,
  input logic [DW-1:0] in_prev,
  input logic          out_valid,
  input logic [DW-1:0] out_pix
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_pix == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 (!out_valid && $stable(out_pix)));

  // R3
  between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |->
      ((out_pix >= $past(in_cur, 2)) || (out_pix >= $past(in_prev, 2))) &&
      ((out_pix <= $past(in_cur, 2)) || (out_pix <= $past(in_prev, 2))));

  // R11
  equal_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cur == in_prev) |-> ##2 (out_pix == $past(in_cur, 2)));

endmodule

bind tnr_blend tnr_blend_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cur(in_cur),
  .in_prev(in_prev), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/tb_tnr_blend.sv
module tb_tnr_blend;
  localparam int PERIOD = 10;
  localparam int COLW = 11;
  localparam int NVEC = 10;
  // {cur, prev, expected} with the threshold ladder 1,2,2,4,8,12,16,24 and gain x1
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd100, 8'd100, 8'd100},
    {8'd101, 8'd100, 8'd100},
    {8'd103, 8'd100, 8'd101},
    {8'd50,  8'd55,  8'd53},
    {8'd200, 8'd190, 8'd196},
    {8'd0,   8'd20,  8'd3},
    {8'd124, 8'd100, 8'd124},
    {8'd255, 8'd0,   8'd255},
    {8'd98,  8'd100, 8'd99},
    {8'd112, 8'd100, 8'd109}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic split_en = 1'b0;
  logic [COLW-1:0] split_col = '0, in_col = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_cur = '0, in_prev = '0;
  logic out_valid;
  logic [7:0] out_pix;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  tnr_blend #(.DW(8), .COLW(COLW), .COMP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .split_en(split_en), .split_col(split_col),
    .in_valid(in_valid), .in_col(in_col), .in_cur(in_cur), .in_prev(in_prev),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pix(input string req, input int c, input int p, input int col, input int exp);
    @(negedge clk);
    in_valid = 1'b1; in_cur = 8'(c); in_prev = 8'(p); in_col = COLW'(col);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, int'(out_valid), 1);
    check(req, int'(out_pix), exp);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL R2: watchdog expired, got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset data", int'(out_pix), 0);
    pix("R1 passthrough", 77, 10, 0, 77);

    @(negedge clk);
    in_valid = 1'b1; in_cur = 8'd30; in_prev = 8'd60;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 one edge", int'(out_valid), 0);
    @(negedge clk);
    check("R2 two edges", int'(out_valid), 1);

    wr(8'h10, 8'h21); wr(8'h11, 8'h21); wr(8'h12, 8'h32); wr(8'h13, 8'h32);
    for (int i = 0; i < NVEC; i++)
      pix("R3 R4 R5 table", int'(VEC[i][23:16]), int'(VEC[i][15:8]), 0, int'(VEC[i][7:0]));

    wr(8'h14, 8'h30);
    pix("R6 gain 1/8", 124, 100, 0, 109);
    wr(8'h14, 8'h50);
    pix("R6 gain x4", 55, 50, 0, 54);
    pix("R6 saturate", 166, 100, 0, 166);

    wr(8'h14, 8'h80);
    pix("R7 fixed 0", 200, 40, 0, 40);
    wr(8'h14, 8'h8F);
    pix("R7 fixed 15", 200, 40, 0, 200);
    wr(8'h14, 8'h88);
    pix("R7 fixed 8", 200, 40, 0, 120);

    wr(8'h14, 8'h00);
    split_en = 1'b1; split_col = COLW'(100);
    pix("R8 left", 200, 40, 50, 40);
    pix("R8 edge left", 200, 40, 99, 40);
    pix("R8 right", 200, 40, 100, 200);
    split_en = 1'b0;
    pix("R8 off", 200, 40, 50, 200);

    wr(8'h15, 8'h80);
    wr(8'h20, 8'h80);
    pix("R9 other addr", 200, 40, 0, 200);

    @(negedge clk);
    in_valid = 1'b0; in_cur = 8'd5; in_prev = 8'd250;
    repeat (3) @(negedge clk);
    check("R10 idle valid", int'(out_valid), 0);
    check("R10 idle hold", int'(out_pix), 200);

    wr(8'h14, 8'h88);
    pix("R11 equal", 173, 173, 0, 173);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule